// File: doc/BRIEF.md
# Keyed Clock Divider with Delayed Copy

The block divides a fast input clock by a programmable ratio from 1 to 32. It produces a divided waveform plus a second copy of that waveform. The copy can be held back by zero to three input cycles, can be inverted, and can be switched off. Both outputs are synchronous to the input clock. The divided output acts as a clock-enable style waveform that a downstream clock gate or generator turns into a real clock.

Software sets the block through a two-register write port, one register for the ratio and one for the phase copy. Each written word carries a fixed key in its upper bits. A word whose key is wrong is not dropped. Instead the block applies a defined fallback setting and raises a one-cycle bad-write pulse. Ratio changes wait for the end of the current period, so a pulse is never cut short. A running flag reports when division has started after reset.

Top module: `clkdiv_top`

## Requirements
- R1: A write with `wr_sel_i`=0 loads the pending ratio. Bits 11:5 must equal 7'b1010101, and bits 4:0 then give the ratio: value 0 selects 32, and values 1..31 select themselves.
- R2: A ratio write whose bits 11:5 differ from 7'b1010101 sets the pending ratio to 31.
- R3: After reset the ratio is 16, the phase copy is disabled with shift 0 and no inversion, and all outputs are low.
- R4: For a ratio N ≥ 2, `div_o` is high for the first floor(N/2) cycles of each N-cycle period and low for the rest. For N=1, `div_o` is high on every running cycle.
- R5: The pending ratio becomes active only at the end of the current period. A period in progress always completes at its old length.
- R6: `running_o` is 0 during reset, becomes 1 on the first clock edge after reset is released, and stays at 1. `div_o` stays low while `running_o` is 0, and the first period starts when `running_o` rises.
- R7: A write with `wr_sel_i`=1 loads the phase setting. Bits 1:0 are the shift, bit 2 is the invert flag and bit 3 is the enable. From the next cycle on, `phase_o` equals `div_o` as it was shift cycles earlier, and it is 0 while the enable is clear.
- R8: When the invert flag is set and the active ratio is not 1, `phase_o` is the complement of the delayed waveform.
- R9: While the active ratio is 1, the shift is treated as 0 and the invert flag is ignored.
- R10: A phase write whose bits 11:4 differ from 8'hAA enables the copy with shift 0 and no inversion.
- R11: `bad_wr_o` is high for exactly the one cycle after a write with a wrong key to either register, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the ratio register, 1 selects the phase register |
| wr_data_i | input | 12 | Written word, including its key bits |
| div_o | output | 1 | Divided waveform |
| phase_o | output | 1 | Delayed, optionally inverted copy |
| running_o | output | 1 | Division has started |
| bad_wr_o | output | 1 | One-cycle pulse after a write with a wrong key |

## Verification
The hardest situation to create from the ports is a ratio write that lands at every possible point inside a period. Of these, the write that arrives in the very cycle of the period boundary matters most, because there the old and new ratios meet. The bench writes each of the 32 ratio codes in turn without waiting for a boundary. Because the periods differ in length, the write instants fall at many different counter positions. A cycle-by-cycle model checks that each old period completes at its old length. The phase sweep crosses every shift, invert and enable combination with ratios of 1, 2, 3, 5 and 32. This covers the ratio-1 overrides and the long delays against short periods.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CFG_W      = 12;
  localparam int FIELD_W    = 5;
  localparam int RATIO_W    = FIELD_W + 1;
  localparam int SHIFT_W    = 2;
  localparam int RKEY_W     = CFG_W - FIELD_W;
  localparam int PKEY_LSB   = 4;
  localparam int PKEY_W     = CFG_W - PKEY_LSB;
  localparam logic [RKEY_W-1:0] RATIO_KEY = 7'b1010101;
  localparam logic [PKEY_W-1:0] PHASE_KEY = 8'hAA;
  localparam logic [RATIO_W-1:0] RESET_RATIO = 6'd16;
  localparam logic [RATIO_W-1:0] FALLBACK_RATIO = 6'd31;

  typedef struct packed {
    logic               en;
    logic               inv;
    logic [SHIFT_W-1:0] shift;
  } phase_cfg_t;

  function automatic logic ratio_key_ok(input logic [CFG_W-1:0] w);
    return w[CFG_W-1:FIELD_W] == RATIO_KEY;
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_decode(input logic [CFG_W-1:0] w);
    logic [RATIO_W-1:0] r;
    if (!ratio_key_ok(w)) r = FALLBACK_RATIO;
    else if (w[FIELD_W-1:0] == '0) r = RATIO_W'(1) << FIELD_W;
    else r = {1'b0, w[FIELD_W-1:0]};
    return r;
  endfunction

  function automatic logic phase_key_ok(input logic [CFG_W-1:0] w);
    return w[CFG_W-1:PKEY_LSB] == PHASE_KEY;
  endfunction

  function automatic phase_cfg_t phase_decode(input logic [CFG_W-1:0] w);
    phase_cfg_t c;
    if (phase_key_ok(w)) begin
      c.shift = w[SHIFT_W-1:0];
      c.inv   = w[SHIFT_W];
      c.en    = w[SHIFT_W+1];
    end else begin
      c.shift = '0;
      c.inv   = 1'b0;
      c.en    = 1'b1;
    end
    return c;
  endfunction

  // high time of one period: half the ratio, rounded down
  function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] r);
    return r >> 1;
  endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [CFG_W-1:0]   wr_data_i,
  output logic [RATIO_W-1:0] pend_ratio_o,
  output phase_cfg_t         phase_cfg_o,
  output logic               bad_wr_o
);

  logic ratio_wr, phase_wr, key_bad;
  logic [RATIO_W-1:0] pend_q;
  phase_cfg_t         phase_q;
  logic               bad_q;

  assign ratio_wr = wr_en_i && !wr_sel_i;
  assign phase_wr = wr_en_i &&  wr_sel_i;
  assign key_bad  = (ratio_wr && !ratio_key_ok(wr_data_i)) ||
                    (phase_wr && !phase_key_ok(wr_data_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= RESET_RATIO;
      phase_q <= '0;
      bad_q   <= 1'b0;
    end else begin
      if (ratio_wr) pend_q  <= ratio_decode(wr_data_i);
      if (phase_wr) phase_q <= phase_decode(wr_data_i);
      bad_q <= key_bad;
    end
  end

  assign pend_ratio_o = pend_q;
  assign phase_cfg_o  = phase_q;
  assign bad_wr_o     = bad_q;

  p_bad_origin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr_o |-> $past(wr_en_i));
  p_pend_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_ratio_o >= 1) && (pend_ratio_o <= 32));

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] pend_ratio_i,
  output logic [RATIO_W-1:0] act_ratio_o,
  output logic               wrap_o,
  output logic               running_o,
  output logic               div_o
);

  logic [FIELD_W-1:0] cnt_q;
  logic [RATIO_W-1:0] act_q;
  logic               run_q;
  logic               wrap;

  assign wrap = ({1'b0, cnt_q} == act_q - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= RESET_RATIO;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (wrap) begin
          cnt_q <= '0;
          act_q <= pend_ratio_i;
        end else begin
          cnt_q <= cnt_q + FIELD_W'(1);
        end
      end
    end
  end

  assign div_o       = run_q && ((act_q == RATIO_W'(1)) ||
                                 ({1'b0, cnt_q} < high_len(act_q)));
  assign act_ratio_o = act_q;
  assign wrap_o      = wrap;
  assign running_o   = run_q;

  p_ratio_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio_o >= 1) && (act_ratio_o <= 32));
  p_hold_midperiod_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !wrap_o) |=> $stable(act_ratio_o));
  p_running_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |=> running_o);
  p_div1_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && act_ratio_o == 1) |-> div_o);
  p_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !div_o);

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
  import clkdiv_pkg::*;
#(
  parameter int DEPTH = (1 << SHIFT_W) - 1
)(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               div_i,
  input  logic [RATIO_W-1:0] act_ratio_i,
  input  phase_cfg_t         cfg_i,
  output logic               phase_o
);

  logic [DEPTH-1:0]   hist_q;
  logic [SHIFT_W-1:0] shift_eff;
  logic               inv_eff, delayed, is_div1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[DEPTH-2:0], div_i};
  end

  assign is_div1   = (act_ratio_i == RATIO_W'(1));
  assign shift_eff = is_div1 ? '0 : cfg_i.shift;
  assign inv_eff   = cfg_i.inv && !is_div1;

  always_comb begin
    delayed = div_i;
    for (int k = 1; k <= DEPTH; k++) begin
      if (int'(shift_eff) == k) delayed = hist_q[k-1];
    end
  end

  assign phase_o = cfg_i.en && (delayed ^ inv_eff);

  p_phase_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |-> !phase_o);
  p_div1_plain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_div1 && cfg_i.en) |-> (phase_o == div_i));

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic             div_o,
  output logic             phase_o,
  output logic             running_o,
  output logic             bad_wr_o
);

  logic [RATIO_W-1:0] pend_ratio, act_ratio;
  phase_cfg_t         phase_cfg;
  logic               wrap;

  clkdiv_cfg i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .pend_ratio_o(pend_ratio), .phase_cfg_o(phase_cfg), .bad_wr_o(bad_wr_o)
  );

  clkdiv_core i_core (
    .clk_i, .rst_ni, .pend_ratio_i(pend_ratio),
    .act_ratio_o(act_ratio), .wrap_o(wrap), .running_o(running_o), .div_o(div_o)
  );

  clkdiv_phase i_phase (
    .clk_i, .rst_ni, .div_i(div_o), .act_ratio_i(act_ratio),
    .cfg_i(phase_cfg), .phase_o(phase_o)
  );

  p_wrap_needs_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && wrap && act_ratio != 1) |=> !$stable(div_o) || (act_ratio == 1));

endmodule

// File: tb/test_clkdiv_top.sv
module test_clkdiv_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [11:0] wr_data = '0;
  logic div_o, phase_o, running_o, bad_wr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R3";

  always #5 clk = ~clk;

  clkdiv_top i_clkdiv_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .div_o(div_o), .phase_o(phase_o),
    .running_o(running_o), .bad_wr_o(bad_wr_o)
  );

  // ---- reference model, written from the requirements ----
  int m_act = 16, m_pend = 16, m_cnt = 0;
  bit m_run = 0, m_bad = 0;
  int m_shift = 0;
  bit m_inv = 0, m_en = 0;
  bit m_h1 = 0, m_h2 = 0, m_h3 = 0;

  function automatic bit mdiv();
    if (!m_run) return 1'b0;
    if (m_act == 1) return 1'b1;
    return m_cnt < (m_act / 2);
  endfunction

  function automatic bit mphase();
    int s;
    bit d;
    if (!m_en) return 1'b0;
    s = (m_act == 1) ? 0 : m_shift;
    case (s)
      0: d = mdiv();
      1: d = m_h1;
      2: d = m_h2;
      default: d = m_h3;
    endcase
    return d ^ (m_inv && m_act != 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act <= 16; m_pend <= 16; m_cnt <= 0; m_run <= 0; m_bad <= 0;
      m_shift <= 0; m_inv <= 0; m_en <= 0; m_h1 <= 0; m_h2 <= 0; m_h3 <= 0;
    end else begin
      m_h1 <= mdiv(); m_h2 <= m_h1; m_h3 <= m_h2;
      m_run <= 1;
      if (m_run) begin
        if (m_cnt + 1 == m_act) begin m_cnt <= 0; m_act <= m_pend; end
        else m_cnt <= m_cnt + 1;
      end
      m_bad <= 0;
      if (wr_en && !wr_sel) begin
        if ((wr_data >> 5) == 12'h55) m_pend <= (wr_data % 32 == 0) ? 32 : int'(wr_data % 32);
        else begin m_pend <= 31; m_bad <= 1; end
      end
      if (wr_en && wr_sel) begin
        if ((wr_data >> 4) == 12'hAA) begin
          m_shift <= int'(wr_data % 4); m_inv <= wr_data[2]; m_en <= wr_data[3];
        end else begin
          m_shift <= 0; m_inv <= 0; m_en <= 1; m_bad <= 1;
        end
      end
    end
  end

  task automatic check(string t, string what, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(tag, "div_o", div_o, mdiv());
    check(tag, "phase_o", phase_o, mphase());
    check("R6", "running_o", running_o, m_run);
    check("R11", "bad_wr_o", bad_wr_o, m_bad);
  endtask

  // one cycle: compare outputs mid-low phase, then drive the next inputs
  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      wr_en = 1'b0;
    end
  endtask

  task automatic write(bit sel, logic [11:0] d);
    @(negedge clk);
    compare_all();
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R3";
    check("R3", "div_o in reset", div_o, 1'b0);
    check("R3", "phase_o in reset", phase_o, 1'b0);
    check("R6", "running_o in reset", running_o, 1'b0);
    check("R11", "bad_wr_o in reset", bad_wr_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6", "running after release", running_o, 1'b1);
    tag = "R3 R4 reset ratio 16";
    cycles(40);

    // R1 R4 R5: every ratio code, written at varying points of the period
    for (int d = 0; d < 32; d++) begin
      tag = $sformatf("R1 R4 R5 code %0d", d);
      write(1'b0, 12'hAA0 | 12'(d));
      cycles(2 * ((d == 0) ? 32 : d) + 35);
    end

    // R2 R11: wrong ratio key
    tag = "R2 wrong ratio key";
    write(1'b0, 12'h123);
    cycles(70);
    write(1'b0, 12'hAA5);
    write(1'b0, 12'h7E5);
    cycles(70);

    // R7 R8 R9: phase sweep across ratios
    for (int ri = 0; ri < 5; ri++) begin
      int r;
      r = (ri == 0) ? 1 : (ri == 1) ? 2 : (ri == 2) ? 3 : (ri == 3) ? 5 : 32;
      write(1'b0, 12'hAA0 | 12'(r % 32));
      cycles(70);
      for (int p = 0; p < 16; p++) begin
        tag = $sformatf("R7 R8 R9 ratio %0d phase %0d", r, p);
        write(1'b1, 12'hAA0 | 12'(p));
        cycles(2 * r + 8);
      end
      tag = $sformatf("R10 ratio %0d", r);
      write(1'b1, 12'h55C);
      cycles(2 * r + 8);
    end

    // R10 R11: wrong phase key after an inverted, shifted setting
    write(1'b0, 12'hAA6);
    cycles(20);
    write(1'b1, 12'hAAF);
    cycles(20);
    tag = "R10 wrong phase key";
    write(1'b1, 12'h00F);
    cycles(30);
    write(1'b1, 12'hAA0);
    tag = "R7 disabled";
    cycles(30);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule